// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by fetching two page-table entries from memory, one after the other. A requester hands over a virtual address, an access kind (read, write or instruction fetch) and a privilege flag, together with the current page-directory base. The walker forms the first-level entry address from the base and the top ten bits of the page number. It reads that entry through a word-read memory port and checks it. It then uses the frame held in that entry, together with the next ten bits of the page number, to form and read the leaf entry.

When the walk ends, the block pulses a result for one cycle. The result carries a fault code, the physical address (frame from the leaf entry, page offset carried through unchanged) and the last entry read, so that a translation cache can store it. A fault can be "none", "not present" or "protection". Only one walk is in flight at a time. Both the request side and the memory request side use a valid/ready handshake. Read data comes back as a one-cycle valid pulse.

Top module: `pt_walker`

## Requirements
- R1: While reset is asserted and right after it is released, `req_ready` is 1, `mem_req_valid` is 0 and `res_valid` is 0.
- R2: The first read goes to `{pdbr[31:12], vaddr[31:22], 2'b00}`. The low 12 bits of the base register have no effect.
- R3: The second read goes to `{entry1[31:12], vaddr[21:12], 2'b00}`. It is issued only after the first read's data has arrived and passed its checks, so a successful walk makes exactly two reads.
- R4: On success `res_fault` is 0 and `res_paddr` is `{entry2[31:12], vaddr[11:0]}`. `res_pte` is the leaf entry as read.
- R5: Entry bit 0 is the present flag. If it is clear in the first-level entry, the walk ends with fault code 1 after a single read. If it is clear in the leaf, the walk ends with fault code 1 after two reads.
- R6: Access code 0 (read) needs entry bit 1, code 1 (write) needs bit 2 and code 2 (fetch) needs bit 3. An entry with bit 4 (kernel-only) set faults when `req_user` is 1. Either violation gives fault code 2. Both levels are checked, and a protection fault at the first level ends the walk after one read.
- R7: A not-present entry reports code 1 even when its permission bits would also fail.
- R8: `req_ready` is low from the accepted request until the result. `res_valid` lasts exactly one cycle.
- R9: On any fault `res_paddr` is 0 and `res_pte` holds the entry that faulted.
- R10: A memory request that is not yet accepted keeps `mem_req_valid` high and `mem_req_addr` unchanged. No memory request is raised while the walker is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle, can take a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| req_user | input | 1 | 1 = user privilege, 0 = kernel |
| pdbr | input | 32 | Page-directory base (frame in bits 31:12) |
| mem_req_valid | output | 1 | Memory word read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data valid, one cycle |
| mem_rsp_data | input | 32 | Read data word |
| res_valid | output | 1 | Result pulse |
| res_fault | output | 2 | 0 none, 1 not present, 2 protection |
| res_paddr | output | 32 | Physical address, 0 on fault |
| res_pte | output | 32 | Leaf entry, or the faulting entry |

## Verification
The bench builds the walker with its default split: 32-bit addresses, a 12-bit offset and 10-bit indices at each level. At these values the index extremes (0 and 1023) and an all-ones page offset are easy to hit directly. Random tables with mostly-set flags reach every fault path at both levels. The memory model varies its accept and response delays, so the request-hold rule and the strict ordering of the two reads are exercised under stall.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_ABSENT = 2'd1,
    FLT_PROT   = 2'd2
  } flt_t;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2
  } acc_t;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_L1_REQ  = 3'd1,
    ST_L1_WAIT = 3'd2,
    ST_L2_REQ  = 3'd3,
    ST_L2_WAIT = 3'd4,
    ST_DONE    = 3'd5
  } walk_state_t;

  localparam int FLAG_W      = 5;
  localparam int FB_PRESENT  = 0;
  localparam int FB_READ     = 1;
  localparam int FB_WRITE    = 2;
  localparam int FB_EXEC     = 3;
  localparam int FB_KERNEL   = 4;

endpackage

// File: rtl/pt_walker_rstsync.sv
module pt_walker_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/pt_walker_addr.sv
module pt_walker_addr #(
  parameter int ADDR_W     = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int IDX_W      = 10
) (
  input  logic                         second,
  input  logic [ADDR_W-1:0]            dir_base,
  input  logic [ADDR_W-1:0]            tbl_entry,
  input  logic [ADDR_W-PAGE_SHIFT-1:0] vpn,
  output logic [ADDR_W-1:0]            entry_addr
);

  localparam int VPN_W    = ADDR_W - PAGE_SHIFT;
  localparam int TOP_W    = VPN_W - IDX_W;
  localparam int ENTRY_SH = 2;
  localparam logic [ADDR_W-1:0] FRAME_MASK = {{VPN_W{1'b1}}, {PAGE_SHIFT{1'b0}}};

  logic [ADDR_W-1:0] tbl_base;
  logic [ADDR_W-1:0] idx_ext;

  always_comb begin
    if (second) begin
      tbl_base = tbl_entry & FRAME_MASK;
      idx_ext  = ADDR_W'(vpn[IDX_W-1:0]);
    end else begin
      tbl_base = dir_base & FRAME_MASK;
      idx_ext  = ADDR_W'(vpn[VPN_W-1:VPN_W-TOP_W]);
    end
    entry_addr = tbl_base | (idx_ext << ENTRY_SH);
  end

endmodule

// File: rtl/pt_walker_check.sv
module pt_walker_check
  import pt_walker_pkg::*;
(
  input  logic [FLAG_W-1:0] flags,
  input  logic [1:0]        acc,
  input  logic              user,
  output flt_t              fault
);

  logic perm_ok;

  always_comb begin
    case (acc)
      ACC_STORE: perm_ok = flags[FB_WRITE];
      ACC_FETCH: perm_ok = flags[FB_EXEC];
      default:   perm_ok = flags[FB_READ];
    endcase
    if (!flags[FB_PRESENT]) begin
      fault = FLT_ABSENT;
    end else if ((user && flags[FB_KERNEL]) || !perm_ok) begin
      fault = FLT_PROT;
    end else begin
      fault = FLT_NONE;
    end
  end

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int IDX_W      = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic [1:0]        req_acc,
  input  logic              req_user,
  input  logic [ADDR_W-1:0] pdbr,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [ADDR_W-1:0] mem_rsp_data,
  output logic              res_valid,
  output logic [1:0]        res_fault,
  output logic [ADDR_W-1:0] res_paddr,
  output logic [ADDR_W-1:0] res_pte
);

  localparam int VPN_W = ADDR_W - PAGE_SHIFT;
  localparam logic [ADDR_W-1:0] OFF_MASK = {{VPN_W{1'b0}}, {PAGE_SHIFT{1'b1}}};

  logic        srst_n;
  walk_state_t state_q, state_d;
  logic        cap_req, cap_l1, cap_res;
  flt_t        chk_fault;
  flt_t        fault_d, fault_q;

  logic [ADDR_W-1:0] va_q, base_q, l1pte_q, pte_q;
  logic [1:0]        acc_q;
  logic              user_q;

  pt_walker_rstsync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  pt_walker_addr #(
    .ADDR_W     (ADDR_W),
    .PAGE_SHIFT (PAGE_SHIFT),
    .IDX_W      (IDX_W)
  ) u_addr (
    .second     (state_q == ST_L2_REQ),
    .dir_base   (base_q),
    .tbl_entry  (l1pte_q),
    .vpn        (va_q[ADDR_W-1:PAGE_SHIFT]),
    .entry_addr (mem_req_addr)
  );

  pt_walker_check u_chk (
    .flags (mem_rsp_data[FLAG_W-1:0]),
    .acc   (acc_q),
    .user  (user_q),
    .fault (chk_fault)
  );

  // next-state process
  always_comb begin
    state_d = state_q;
    cap_req = 1'b0;
    cap_l1  = 1'b0;
    cap_res = 1'b0;
    fault_d = FLT_NONE;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          cap_req = 1'b1;
          state_d = ST_L1_REQ;
        end
      end
      ST_L1_REQ: begin
        if (mem_req_ready) state_d = ST_L1_WAIT;
      end
      ST_L1_WAIT: begin
        if (mem_rsp_valid) begin
          if (chk_fault != FLT_NONE) begin
            cap_res = 1'b1;
            fault_d = chk_fault;
            state_d = ST_DONE;
          end else begin
            cap_l1  = 1'b1;
            state_d = ST_L2_REQ;
          end
        end
      end
      ST_L2_REQ: begin
        if (mem_req_ready) state_d = ST_L2_WAIT;
      end
      ST_L2_WAIT: begin
        if (mem_rsp_valid) begin
          cap_res = 1'b1;
          fault_d = chk_fault;
          state_d = ST_DONE;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // control register
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  // datapath registers with explicit enables
  always_ff @(posedge clk) begin
    if (cap_req) begin
      va_q   <= req_vaddr;
      acc_q  <= req_acc;
      user_q <= req_user;
      base_q <= pdbr;
    end
    if (cap_l1) begin
      l1pte_q <= mem_rsp_data;
    end
    if (cap_res) begin
      pte_q   <= mem_rsp_data;
      fault_q <= fault_d;
    end
  end

  assign req_ready     = (state_q == ST_IDLE);
  assign mem_req_valid = (state_q == ST_L1_REQ) || (state_q == ST_L2_REQ);
  assign res_valid     = (state_q == ST_DONE);
  assign res_fault     = fault_q;
  assign res_pte       = pte_q;
  assign res_paddr     = (fault_q == FLT_NONE) ?
                         ((pte_q & ~OFF_MASK) | (va_q & OFF_MASK)) : '0;

endmodule

// File: rtl/pt_walker_sva.sv
module pt_walker_sva #(
  parameter int ADDR_W     = 32,
  parameter int PAGE_SHIFT = 12
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  req_valid,
  input logic                  req_ready,
  input logic [PAGE_SHIFT-1:0] req_off,
  input logic                  mem_req_valid,
  input logic                  mem_req_ready,
  input logic [ADDR_W-1:0]     mem_req_addr,
  input logic                  res_valid,
  input logic [1:0]            res_fault,
  input logic [ADDR_W-1:0]     res_paddr
);

  logic [PAGE_SHIFT-1:0] off_q;

  always_ff @(posedge clk) begin
    if (req_valid && req_ready) off_q <= req_off;
  end

  a_r8_busy_at_result: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !req_ready);

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  a_r10_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  a_r10_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req_valid);

  a_r9_zero_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_fault != 2'd0) |-> (res_paddr == '0));

  a_r4_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_fault == 2'd0) |-> (res_paddr[PAGE_SHIFT-1:0] == off_q));

  a_r4_fault_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_fault != 2'd3));

endmodule

bind pt_walker pt_walker_sva #(
  .ADDR_W     (ADDR_W),
  .PAGE_SHIFT (PAGE_SHIFT)
) u_sva (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_off       (req_vaddr[PAGE_SHIFT-1:0]),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .res_valid     (res_valid),
  .res_fault     (res_fault),
  .res_paddr     (res_paddr)
);

// File: tb/pt_walker_tb_top.sv
module pt_walker_tb_top;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_vaddr;
  logic [1:0]  req_acc;
  logic        req_user;
  logic [31:0] pdbr;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;
  logic        res_valid;
  logic [1:0]  res_fault;
  logic [31:0] res_paddr;
  logic [31:0] res_pte;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  logic [31:0] mem [logic [31:0]];
  int          nrd;
  logic [31:0] rd_addr [2];

  pt_walker dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_acc(req_acc), .req_user(req_user), .pdbr(pdbr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .res_valid(res_valid),
    .res_fault(res_fault), .res_paddr(res_paddr), .res_pte(res_pte)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [31:0] rdm(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  function automatic logic [1:0] exp_fault(input logic [31:0] e, input logic [1:0] acc,
                                           input logic usr);
    logic ok;
    if (!e[0]) return 2'd1;
    case (acc)
      2'd1:    ok = e[2];
      2'd2:    ok = e[3];
      default: ok = e[1];
    endcase
    if ((usr && e[4]) || !ok) return 2'd2;
    return 2'd0;
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  // memory model: random accept and response delay
  initial begin
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = 32'h0;
    forever begin
      logic [31:0] a;
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      mem_req_ready = ($urandom % 3) != 0;
      if (mem_req_valid && mem_req_ready) begin
        a = mem_req_addr;
        if (nrd < 2) rd_addr[nrd] = a;
        nrd++;
        @(negedge clk);
        mem_req_ready = 1'b0;
        repeat ($urandom % 3) @(negedge clk);
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = rdm(a);
      end
    end
  end

  task automatic walk(input logic [31:0] base, input logic [31:0] va,
                      input logic [1:0] acc, input logic usr);
    logic [31:0] a1, a2, e1, e2, pte, pa;
    logic [1:0]  f;
    int          nexp;
    a1 = {base[31:12], va[31:22], 2'b00};
    e1 = rdm(a1);
    a2 = {e1[31:12], va[21:12], 2'b00};
    e2 = rdm(a2);
    f  = exp_fault(e1, acc, usr);
    nexp = 1;
    pte  = e1;
    if (f == 2'd0) begin
      nexp = 2;
      f    = exp_fault(e2, acc, usr);
      pte  = e2;
    end
    pa = (f == 2'd0) ? {e2[31:12], va[11:0]} : 32'h0;

    @(negedge clk);
    nrd       = 0;
    req_valid = 1'b1;
    req_vaddr = va;
    req_acc   = acc;
    req_user  = usr;
    pdbr      = base;
    @(negedge clk);
    req_valid = 1'b0;
    req_vaddr = $urandom;
    pdbr      = $urandom;
    check("R8", "ready during walk", {31'd0, req_ready}, 32'd0);
    while (!res_valid) @(negedge clk);
    check("R2", "first read address", rd_addr[0], a1);
    if (nexp == 2) check("R3", "second read address", rd_addr[1], a2);
    check(f == 2'd0 ? "R3" : "R5", "read count", nrd, nexp);
    check(f == 2'd2 ? "R6" : (f == 2'd1 ? "R7" : "R4"), "fault code", {30'd0, res_fault},
          {30'd0, f});
    check(f == 2'd0 ? "R4" : "R9", "physical address", res_paddr, pa);
    check(f == 2'd0 ? "R4" : "R9", "returned entry", res_pte, pte);
    @(negedge clk);
    check("R8", "result pulse width", {31'd0, res_valid}, 32'd0);
  endtask

  task automatic setup(input logic [31:0] base, input logic [31:0] va,
                       input logic [31:0] e1, input logic [31:0] e2);
    mem.delete();
    mem[{base[31:12], va[31:22], 2'b00}] = e1;
    mem[{e1[31:12], va[21:12], 2'b00}]   = e2;
  endtask

  initial begin
    int dummy;
    dummy = $urandom(32'd4242);
    req_valid = 1'b0;
    req_vaddr = '0;
    req_acc   = '0;
    req_user  = 1'b0;
    pdbr      = '0;
    nrd       = 0;
    rst_n     = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "ready in reset", {31'd0, req_ready}, 32'd1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "ready after reset", {31'd0, req_ready}, 32'd1);
    check("R1", "mem valid after reset", {31'd0, mem_req_valid}, 32'd0);
    check("R1", "result after reset", {31'd0, res_valid}, 32'd0);

    // R2 R4: base low bits ignored, top index and all-ones offset
    setup(32'h0040_0ABC, 32'hFFC0_1FFF, 32'h1234_500F, 32'hABCD_E003);
    walk(32'h0040_0ABC, 32'hFFC0_1FFF, 2'd0, 1'b1);
    // R5: first level not present, permissions set (R7)
    setup(32'h0010_0000, 32'h0000_0123, 32'h5555_500E, 32'hFFFF_F00F);
    walk(32'h0010_0000, 32'h0000_0123, 2'd1, 1'b0);
    // R5: leaf not present
    setup(32'h0020_0000, 32'h1234_5678, 32'h0003_000F, 32'h7777_701E);
    walk(32'h0020_0000, 32'h1234_5678, 2'd0, 1'b0);
    // R6: user touches kernel-only leaf
    setup(32'h0030_0000, 32'h8000_0010, 32'h0004_000F, 32'h0009_901F);
    walk(32'h0030_0000, 32'h8000_0010, 2'd0, 1'b1);
    // R6: write to read-only first-level entry ends after one read
    setup(32'h0050_0000, 32'h4000_3000, 32'h0006_0003, 32'h000A_000F);
    walk(32'h0050_0000, 32'h4000_3000, 2'd1, 1'b0);
    // R6: kernel fetch from kernel-only executable page succeeds
    setup(32'h0060_0000, 32'h0040_2ABC, 32'h0007_001F, 32'h000B_B019);
    walk(32'h0060_0000, 32'h0040_2ABC, 2'd2, 1'b0);

    for (int i = 0; i < 400; i++) begin
      logic [31:0] b, v, e1, e2;
      b  = $urandom;
      v  = $urandom;
      e1 = {$urandom, 12'h0} >> 12 << 12;
      e1[0] = ($urandom % 8) != 0;
      e1[1] = ($urandom % 4) != 0;
      e1[2] = ($urandom % 4) != 0;
      e1[3] = ($urandom % 4) != 0;
      e1[4] = ($urandom % 4) == 0;
      e1[5] = $urandom;
      e2 = $urandom;
      e2[0] = ($urandom % 8) != 0;
      e2[1] = ($urandom % 4) != 0;
      e2[2] = ($urandom % 4) != 0;
      e2[3] = ($urandom % 4) != 0;
      e2[4] = ($urandom % 4) == 0;
      setup(b, v, e1, e2);
      walk(b, v, 2'($urandom % 3), 1'($urandom));
    end
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog run did not finish actual=hung expected=done");
    summary();
  end

endmodule